// File: doc/BRIEF.md
# Multi-Counter Timestamp Capture Unit

This block keeps five free-running time counters and takes a coherent snapshot of all of them on request. Two counters are one bus word wide and three are two bus words wide. Software writes a control word that arms one of two triggers. The on-demand trigger captures at once. The event trigger waits for a rising edge on an external event line. All five counters are copied into read-only snapshot registers on a single clock edge. The trigger then clears, and a sticky completion flag is raised.

While the completion flag is set, the snapshots are frozen. Any trigger armed in that time is held and does not fire until software clears the flag by writing 1 to it. The control word also holds five configuration bits, which software writes before arming and which survive every capture. Reads come back combinationally from the current address. Writes take effect on the clock edge.

Top module: `tss_top`

## Requirements
- R1: Reset is asynchronous and active low. It is released inside the block on the second rising clock edge after `rst_n` goes high. After reset, the control word and all snapshot words read 0, and addresses 9 and above always read 0.
- R2: After reset release, every counter starts at 0 and adds 1 on every rising edge. Narrow counters wrap at 2^BUS_W and wide counters at 2^(2·BUS_W). A snapshot holds the counter value from just before its capture edge.
- R3: Control word at address 0. Bit 1 is the on-demand trigger, bit 0 the event trigger, bit 2 the completion flag and bits 7:3 the configuration. Writing bit 1 = 1 with bit 0 = 0 sets bit 1. The snapshots load on the next edge. One edge later, bit 1 clears and bit 2 sets.
- R4: Writing bit 0 = 1 with bit 1 = 0 arms the event trigger. Bit 0 stays 1 until the event input is sampled high at an edge after being sampled low at the previous edge. The snapshots load on that edge, and bit 0 clears and bit 2 sets one edge later.
- R5: A control write with bits 1:0 = 11 starts no capture, and both trigger bits stay 0.
- R6: While either trigger bit is 1, a control write cannot change the trigger bits.
- R7: Writing 1 to bit 2 clears the completion flag. Writing 0 to it leaves the flag unchanged. The flag is set only by a finished capture.
- R8: While bit 2 is 1, the snapshots do not change. A trigger armed in that time reads back as 1 and stays pending. An on-demand capture then happens on the first edge after the edge that clears the flag.
- R9: Configuration bits 7:3 read back as last written, and captures leave them unchanged.
- R10: Addresses 1 and 2 hold the narrow snapshots. Addresses 3 to 8 hold the wide snapshots, low word at the lower address. Writes to addresses 1 to 8 have no effect.
- R11: An event rising edge does not capture if no event trigger is armed, if the event input was already high when the trigger was armed, or if the completion flag is 1. Such an edge is not remembered for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for `reg_addr` (combinational) |
| evt_in | input | 1 | External capture event, synchronous to `clk` |

## Verification
The bench builds the unit with BUS_W = 8 and ADDR_W = 4. This makes the narrow counters 8 bits and the wide counters 16 bits wide. With these widths, a sweep of about 100,000 cycles of on-demand captures passes through many narrow wraps and a full wide wrap, and it exercises every high-word value region. The bench predicts each snapshot from the edge count since reset release. The same small configuration also makes the full address space of 16 words quick to cover, including the unmapped words.

// File: rtl/tss_pkg.sv
package tss_pkg;

  localparam int N_NARROW    = 2;
  localparam int N_WIDE      = 3;

  localparam int CTRL_ADDR   = 0;
  localparam int NARROW_BASE = 1;
  localparam int WIDE_BASE   = NARROW_BASE + N_NARROW;
  localparam int MAP_WORDS   = WIDE_BASE + 2 * N_WIDE;

  localparam int CTRL_USED   = 8;
  localparam int BIT_DONE    = 2;
  localparam int CFG_LSB     = 3;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_EVT  = 2'b01,
    TRIG_NOW  = 2'b10,
    TRIG_BAD  = 2'b11
  } trig_t;

  // Configuration bits 7:3 of the control word, enable at bit 3.
  typedef struct packed {
    logic dma_b;
    logic wall_sel;
    logic link_sel;
    logic dma_a;
    logic enable;
  } cfg_t;

endpackage

// File: rtl/tss_rst_sync.sv
module tss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/tss_counters.sv
module tss_counters
  import tss_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  output logic [N_NARROW-1:0][W-1:0]        narrow_o,
  output logic [N_WIDE-1:0][2*W-1:0]        wide_o
);

  localparam int WW = 2 * W;

  logic cnt_en;
  assign cnt_en = 1'b1;

  for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    always_comb begin
      cnt_d = cnt_q + W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
    assign narrow_o[g] = cnt_q;
  end

  for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
    logic [WW-1:0] cnt_q;
    logic [WW-1:0] cnt_d;
    always_comb begin
      cnt_d = cnt_q + WW'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
    assign wide_o[g] = cnt_q;
  end

endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wr,
  input  logic       evt_in,
  output logic [1:0] trig_o,
  output logic       done_o,
  output logic       fin_o,
  output logic       cap_go_o,
  output cfg_t       cfg_o
);

  logic [1:0] trig_q, trig_d;
  logic       done_q, done_d;
  logic       fin_q,  fin_d;
  logic       evt_q;
  cfg_t       cfg_q;

  trig_t      req;
  logic       busy;
  logic       accept;
  logic       evt_rise;
  logic       cap_go;

  always_comb begin
    req      = trig_t'(ctrl_wr[1:0]);
    busy     = |trig_q;
    accept   = ctrl_we && !busy && ((req == TRIG_EVT) || (req == TRIG_NOW));
    evt_rise = evt_in && !evt_q;
    cap_go   = !done_q && !fin_q &&
               (trig_q[1] || (trig_q[0] && evt_rise));
  end

  always_comb begin
    trig_d = trig_q;
    if (fin_q) begin
      trig_d = 2'b00;
    end else if (accept) begin
      trig_d = ctrl_wr[1:0];
    end

    done_d = done_q;
    if (ctrl_we && ctrl_wr[BIT_DONE]) begin
      done_d = 1'b0;
    end
    if (fin_q) begin
      done_d = 1'b1;
    end

    fin_d = cap_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 2'b00;
      done_q <= 1'b0;
      fin_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      trig_q <= trig_d;
      done_q <= done_d;
      fin_q  <= fin_d;
      evt_q  <= evt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ctrl_we) begin
      cfg_q <= cfg_t'(ctrl_wr[7:CFG_LSB]);
    end
  end

  assign trig_o   = trig_q;
  assign done_o   = done_q;
  assign fin_o    = fin_q;
  assign cap_go_o = cap_go;
  assign cfg_o    = cfg_q;

endmodule

// File: rtl/tss_snap.sv
module tss_snap
  import tss_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_go,
  input  logic [N_NARROW-1:0][W-1:0]  narrow_i,
  input  logic [N_WIDE-1:0][2*W-1:0]  wide_i,
  input  logic [W-1:0]                ctrl_word_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic [W-1:0]                rdata_o,
  output logic [N_NARROW-1:0][W-1:0]  snap_n_o,
  output logic [N_WIDE-1:0][2*W-1:0]  snap_w_o
);

  localparam int WW = 2 * W;

  for (genvar g = 0; g < N_NARROW; g++) begin : g_snap_n
    logic [W-1:0] snap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q <= '0;
      end else if (cap_go) begin
        snap_q <= narrow_i[g];
      end
    end
    assign snap_n_o[g] = snap_q;
  end

  for (genvar g = 0; g < N_WIDE; g++) begin : g_snap_w
    logic [WW-1:0] snap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q <= '0;
      end else if (cap_go) begin
        snap_q <= wide_i[g];
      end
    end
    assign snap_w_o[g] = snap_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      rdata_o = ctrl_word_i;
    end
    for (int n = 0; n < N_NARROW; n++) begin
      if (addr_i == ADDR_W'(NARROW_BASE + n)) begin
        rdata_o = snap_n_o[n];
      end
    end
    for (int j = 0; j < N_WIDE; j++) begin
      if (addr_i == ADDR_W'(WIDE_BASE + 2 * j)) begin
        rdata_o = snap_w_o[j][W-1:0];
      end
      if (addr_i == ADDR_W'(WIDE_BASE + 2 * j + 1)) begin
        rdata_o = snap_w_o[j][WW-1:W];
      end
    end
  end

endmodule

// File: rtl/tss_top.sv
module tss_top
  import tss_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              evt_in
);

  logic rst_int_n;
  logic ctrl_we;
  logic [1:0] trig_q;
  logic done_q;
  logic fin_q;
  logic cap_go;
  cfg_t cfg_q;
  logic [BUS_W-1:0] ctrl_word;
  logic unused_wdata_par;

  logic [N_NARROW-1:0][BUS_W-1:0]   cnt_narrow;
  logic [N_WIDE-1:0][2*BUS_W-1:0]   cnt_wide;
  logic [N_NARROW-1:0][BUS_W-1:0]   snap_narrow;
  logic [N_WIDE-1:0][2*BUS_W-1:0]   snap_wide;

  tss_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  tss_counters #(.W(BUS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .narrow_o (cnt_narrow),
    .wide_o   (cnt_wide)
  );

  assign ctrl_we          = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign unused_wdata_par = ^reg_wdata;

  tss_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctrl_we  (ctrl_we),
    .ctrl_wr  (reg_wdata[CTRL_USED-1:0]),
    .evt_in   (evt_in),
    .trig_o   (trig_q),
    .done_o   (done_q),
    .fin_o    (fin_q),
    .cap_go_o (cap_go),
    .cfg_o    (cfg_q)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_USED-1:0] = {cfg_q, done_q, trig_q};
  end

  tss_snap #(.W(BUS_W), .ADDR_W(ADDR_W)) u_snap (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cap_go      (cap_go),
    .narrow_i    (cnt_narrow),
    .wide_i      (cnt_wide),
    .ctrl_word_i (ctrl_word),
    .addr_i      (reg_addr),
    .rdata_o     (reg_rdata),
    .snap_n_o    (snap_narrow),
    .snap_w_o    (snap_wide)
  );

endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     trig,
  input logic           done,
  input logic           fin,
  input logic [W-1:0]   cnt0,
  input logic [W-1:0]   snap0,
  input logic [2*W-1:0] snapw0
);

  assert_trig_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig));

  assert_snap_from_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> (snap0 == $past(cnt0)));

  assert_trig_clear_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|trig) |-> done);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trig) && !fin) |=> (trig == $past(trig)));

  assert_done_only_by_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

  assert_snap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(snap0) && $stable(snapw0)));

endmodule

bind tss_top tss_checker #(.W(BUS_W)) u_tss_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .trig   (trig_q),
  .done   (done_q),
  .fin    (fin_q),
  .cnt0   (cnt_narrow[0]),
  .snap0  (snap_narrow[0]),
  .snapw0 (snap_wide[0])
);

// File: tb/tb_tss_top.sv
`timescale 1ns/1ps
module tb_tss_top;

  localparam int W  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [W-1:0]  reg_wdata;
  logic [W-1:0]  reg_rdata;
  logic          evt_in;

  always #10 clk = ~clk;

  tss_top #(.BUS_W(W), .ADDR_W(AW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in)
  );

  int edges;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d, output int e);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = AW'(a);
    reg_wdata = W'(d);
    @(posedge clk);
    #1;
    e = edges;
    reg_we = 1'b0;
  endtask

  task automatic expect_rd(input string req, input string what, input int a, input int expv);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    check(req, what, 32'(reg_rdata), 32'(expv & 255));
  endtask

  // Snapshot words for a capture taken on edge number cap_edge.
  task automatic expect_snaps(input string req, input int cap_edge);
    int v;
    v = cap_edge - 3;
    for (int n = 0; n < 2; n++) expect_rd(req, "narrow snapshot", 1 + n, v & 255);
    for (int j = 0; j < 3; j++) begin
      expect_rd(req, "wide snapshot low", 3 + 2 * j, v & 255);
      expect_rd(req, "wide snapshot high", 4 + 2 * j, (v >> 8) & 255);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic fire_evt(output int e);
    @(negedge clk);
    evt_in = 1'b1;
    @(posedge clk);
    #1;
    e = edges;
  endtask

  initial begin
    #(190000 * 20);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int w, c, e, last;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; evt_in = 1'b0;
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    idle(5);

    // R1: reset state and unmapped words
    for (int a = 0; a < 16; a++) expect_rd("R1", "reset word", a, 0);

    // R9: configuration bits
    wr(0, 8'hA8, w);
    expect_rd("R9", "cfg readback", 0, 8'hA8);

    // R3: on-demand capture timing
    wr(0, 8'hAA, w);
    expect_rd("R3", "trigger visible", 0, 8'hAA);
    expect_rd("R3", "trigger during capture", 0, 8'hAA);
    expect_rd("R3", "trigger cleared, done set, cfg kept R9", 0, 8'hAC);
    expect_snaps("R3", w + 1);
    last = w + 1;

    // R7: write 0 keeps done, write 1 clears
    wr(0, 8'hA8, w);
    expect_rd("R7", "done kept on write 0", 0, 8'hAC);
    wr(0, 8'hAC, w);
    expect_rd("R7", "done cleared on write 1", 0, 8'hA8);
    expect_snaps("R7", last);

    // R8: trigger pending while done
    wr(0, 8'hAA, w);
    idle(3);
    expect_rd("R8", "done after capture", 0, 8'hAC);
    last = w + 1;
    wr(0, 8'hAA, w);
    idle(10);
    expect_rd("R8", "pending trigger with done", 0, 8'hAE);
    expect_snaps("R8", last);
    wr(0, 8'hAC, c);
    expect_rd("R8", "snapshot before pending capture", 1, (last - 3) & 255);
    expect_rd("R8", "snapshot after pending capture", 1, (c + 1 - 3) & 255);
    idle(2);
    expect_rd("R8", "pending capture done", 0, 8'hAC);
    expect_snaps("R8", c + 1);
    last = c + 1;

    // R5: both trigger bits
    wr(0, 8'hAC, w);
    wr(0, 8'hAB, w);
    expect_rd("R5", "both bits ignored", 0, 8'hA8);
    idle(5);
    expect_rd("R5", "no capture later", 0, 8'hA8);
    expect_snaps("R5", last);

    // R4: event trigger waits for a rising edge
    wr(0, 8'hA9, w);
    idle(20);
    expect_rd("R4", "event trigger armed", 0, 8'hA9);
    // R6: write while busy ignored
    wr(0, 8'hAA, w);
    expect_rd("R6", "busy write ignored", 0, 8'hA9);
    idle(5);
    expect_rd("R6", "still armed", 0, 8'hA9);
    expect_snaps("R6", last);
    fire_evt(e);
    expect_rd("R4", "trigger during capture", 0, 8'hA9);
    expect_rd("R4", "event capture done", 0, 8'hAC);
    expect_snaps("R4", e);
    last = e;

    // R11: event already high when armed
    wr(0, 8'hAC, w);
    wr(0, 8'hA9, w);
    idle(10);
    expect_rd("R11", "high level no capture", 0, 8'hA9);
    expect_snaps("R11", last);
    @(negedge clk); evt_in = 1'b0;
    idle(3);
    fire_evt(e);
    idle(3);
    expect_rd("R4", "capture after new rise", 0, 8'hAC);
    expect_snaps("R4", e);
    last = e;

    // R11: rise while done is ignored and not remembered
    wr(0, 8'hA9, w);
    expect_rd("R11", "armed while done", 0, 8'hAD);
    @(negedge clk); evt_in = 1'b0;
    @(negedge clk); evt_in = 1'b1;
    idle(3);
    expect_snaps("R11", last);
    @(negedge clk); evt_in = 1'b0;
    wr(0, 8'hAC, w);
    expect_rd("R11", "still armed after clear", 0, 8'hA9);
    idle(5);
    expect_rd("R11", "no capture from old rise", 0, 8'hA9);
    expect_snaps("R11", last);
    fire_evt(e);
    idle(3);
    expect_rd("R11", "capture on fresh rise", 0, 8'hAC);
    expect_snaps("R11", e);
    last = e;
    @(negedge clk); evt_in = 1'b0;

    // R10: writes to snapshot words ignored; unmapped reads zero
    for (int a = 1; a < 9; a++) wr(a, 8'h5A, w);
    expect_snaps("R10", last);
    expect_rd("R10", "ctrl untouched", 0, 8'hAC);
    for (int a = 9; a < 16; a++) expect_rd("R10", "unmapped word", a, 0);

    // R2: sweep of captures across counter wraps
    for (int i = 0; i < 40; i++) begin
      wr(0, 8'hAC, w);
      idle(1500 + i * 53);
      wr(0, 8'hAA, w);
      idle(3);
      expect_snaps("R2", w + 1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule